// File: doc/BRIEF.md
# Stereo Record-Level Limiter with Automatic Recovery

This block sets the recording gain of a stereo capture path. It watches the left and right 16-bit two's-complement samples that arrive with a sample strobe, and it drives two 7-bit gain codes. Code 0x00 is mute and code 0x68 is the largest gain. When the louder channel reaches a selectable level, both gains are stepped down together from the smaller of the two current codes. Stepping continues until the input falls below that level. After a quiet interval, the gains are stepped back up toward a programmable reference code.

Each new gain is held back per channel until that channel's signal crosses zero or a timeout expires. This keeps audible clicks out of the recording. All settings are static inputs. A done output reports whether a gain step is in progress. While limiting is disabled, the gains simply follow two manual gain inputs. All timing is counted in sample strobes.

Top module: `stereo_level_ctrl`

## Requirements
- R1: While rst is high and on the first edge after it, gain_left and gain_right equal 0x30 and done is 1.
- R2: With cfg_limit_en low, each gain takes its manual input, saturated at 0x68, one clock later. Samples of any level leave the gains and done unchanged.
- R3: cfg_thr_sel values 0, 1, 2 and 3 select the magnitudes 13046, 16423, 20675 and 26029 (-8, -6, -4, -2 dBFS). A sample pair is loud when the absolute value of either channel is at or above the selected magnitude, with -32768 counting as 32768.
- R4: A limiting step computes min(gain_left, gain_right) - (cfg_att_step + 1), clipped at 0x00, as the new target of both channels.
- R5: With cfg_lim_zc low, a limiting step lands on both channels at the Nth strobe after the strobe that issued it, where N = 1 << cfg_lim_time. Gains never change on a cycle without a strobe unless the manual load is active.
- R6: With cfg_lim_zc high, each channel independently takes the new gain at its first later strobe that is a zero crossing. A zero crossing is a sign bit different from that channel's previous sample, or a sample equal to zero. Otherwise the channel takes the new gain at the (129 << cfg_lim_time)th strobe.
- R7: done falls on the loud strobe that starts limiting. With no step pending, every loud strobe issues a further step. The first strobe that is not loud with no step pending sets done to 1.
- R8: With recovery on, a wait counter counts strobes below the hysteresis floor and is cleared by strobes in [floor, threshold). The floors for cfg_thr_sel 0 to 3 are 10362, 13046, 16423 and 20675. At the (512 << cfg_wait_time)th counted strobe, a recovery step is issued and done falls, but only if the gain is below the reference. Otherwise a new wait starts.
- R9: A recovery step targets min(gain + cfg_rec_step + 1, cfg_ref_gain, 0x68). With cfg_rec_zc low it lands on the next strobe. With cfg_rec_zc high it waits for a zero crossing or the ((512 << cfg_rec_time) + 1)th strobe.
- R10: A loud strobe while a recovery step is pending discards that step and issues a limiting step from the current gains.
- R11: After cfg_limit_en is cleared, no new step is issued and a pending step still completes. done becomes 1 on the clock after no step is pending, and the manual gains are loaded one clock after that.
- R12: Recovery never runs while cfg_limit_en is low, whatever cfg_recover_en is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 16 | Left sample, two's complement |
| smp_right | input | 16 | Right sample, two's complement |
| cfg_limit_en | input | 1 | Enable automatic limiting |
| cfg_recover_en | input | 1 | Enable automatic recovery |
| cfg_thr_sel | input | 2 | Limit level select |
| cfg_att_step | input | 3 | Limiting step size minus one |
| cfg_lim_zc | input | 1 | Zero-crossing wait for limiting steps |
| cfg_lim_time | input | 2 | Limiting timeout or period select |
| cfg_wait_time | input | 2 | Recovery wait select |
| cfg_rec_step | input | 2 | Recovery step size minus one |
| cfg_rec_zc | input | 1 | Zero-crossing wait for recovery steps |
| cfg_rec_time | input | 2 | Recovery timeout select |
| cfg_ref_gain | input | 7 | Recovery ceiling code |
| man_gain_left | input | 7 | Manual left gain |
| man_gain_right | input | 7 | Manual right gain |
| gain_left | output | 7 | Left gain code |
| gain_right | output | 7 | Right gain code |
| done | output | 1 | No automatic step in progress |

## Verification
A wrong controller state shows on done within one strobe. For example, a missed loud sample leaves done high on the very strobe that should drop it, and a stuck step keeps it low on the strobe after the quiet sample. A wrong target shows on the gains as soon as the step lands. A wrong counter shows as a step landing one strobe early or late against the counted window. A lost per-channel sign history shows as one channel changing on a strobe that is not a zero crossing. Recovery wait errors are only seen at the end of a 512-strobe window, so the hysteresis clear is checked right at the count boundary.

// File: rtl/slc_pkg.sv
package slc_pkg;

  typedef enum logic [2:0] {
    ST_MANUAL,
    ST_HOLD,
    ST_LIMIT,
    ST_WAIT,
    ST_RECOVER
  } ctrl_state_t;

  // Level magnitudes on a 16-bit full scale; index 0 is the hysteresis
  // floor of the lowest threshold, indices 1..4 the four thresholds.
  function automatic logic [31:0] level_mag(input logic [2:0] idx);
    case (idx)
      3'd0:    level_mag = 32'd10362;
      3'd1:    level_mag = 32'd13046;
      3'd2:    level_mag = 32'd16423;
      3'd3:    level_mag = 32'd20675;
      default: level_mag = 32'd26029;
    endcase
  endfunction

endpackage

// File: rtl/slc_level_detect.sv
module slc_level_detect #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  input  logic [1:0]       thr_sel,
  output logic             over,
  output logic             in_band,
  output logic [1:0]       zc
);
  import slc_pkg::*;

  localparam int NCH = 2;

  logic [SMP_W-1:0] smp_ch [NCH];
  logic [SMP_W-1:0] mag    [NCH];
  logic [SMP_W-1:0] peak;
  logic [SMP_W-1:0] thr_hi;
  logic [SMP_W-1:0] thr_lo;
  logic [2:0]       idx_hi;
  logic [47:0]      scaled_hi;
  logic [47:0]      scaled_lo;

  assign smp_ch[0] = smp_l;
  assign smp_ch[1] = smp_r;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic prev_sign;
      assign mag[c] = smp_ch[c][SMP_W-1] ? (~smp_ch[c] + 1'b1) : smp_ch[c];
      assign zc[c]  = (smp_ch[c][SMP_W-1] != prev_sign) || (smp_ch[c] == '0);
      always_ff @(posedge clk) begin
        if (rst)            prev_sign <= 1'b0;
        else if (smp_valid) prev_sign <= smp_ch[c][SMP_W-1];
      end
    end
  endgenerate

  assign idx_hi    = {1'b0, thr_sel} + 3'd1;
  assign scaled_hi = ({16'd0, level_mag(idx_hi)} << (SMP_W - 1)) >> 15;
  assign scaled_lo = ({16'd0, level_mag({1'b0, thr_sel})} << (SMP_W - 1)) >> 15;
  assign thr_hi    = scaled_hi[SMP_W-1:0];
  assign thr_lo    = scaled_lo[SMP_W-1:0];

  assign peak    = (mag[0] > mag[1]) ? mag[0] : mag[1];
  assign over    = (peak >= thr_hi);
  assign in_band = (peak >= thr_lo) && !over;

endmodule

// File: rtl/slc_gain_apply.sv
module slc_gain_apply #(
  parameter int GAIN_W   = 7,
  parameter int CNT_W    = 13,
  parameter int GAIN_MAX = 104,
  parameter int RST_GAIN = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              smp_zc,
  input  logic              load,
  input  logic [GAIN_W-1:0] load_gain,
  input  logic              issue,
  input  logic [GAIN_W-1:0] issue_gain,
  input  logic              issue_zc,
  input  logic [CNT_W-1:0]  issue_lim,
  output logic [GAIN_W-1:0] gain,
  output logic              pend
);
  localparam logic [GAIN_W-1:0] MAX_CODE = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] tgt;
  logic              zc_mode;
  logic [CNT_W-1:0]  lim;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic              land;

  assign cnt_inc = cnt + 1'b1;
  assign land    = (zc_mode && smp_zc) || (cnt_inc == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      gain    <= GAIN_W'(RST_GAIN);
      pend    <= 1'b0;
      tgt     <= '0;
      zc_mode <= 1'b0;
      lim     <= '0;
      cnt     <= '0;
    end else if (load) begin
      gain <= (load_gain > MAX_CODE) ? MAX_CODE : load_gain;
      pend <= 1'b0;
    end else if (issue) begin
      tgt     <= issue_gain;
      zc_mode <= issue_zc;
      lim     <= issue_lim;
      cnt     <= '0;
      pend    <= 1'b1;
    end else if (pend && smp_valid) begin
      if (land) begin
        gain <= tgt;
        pend <= 1'b0;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/slc_ctrl.sv
module slc_ctrl #(
  parameter int GAIN_W       = 7,
  parameter int CNT_W        = 13,
  parameter int GAIN_MAX     = 104,
  parameter int LIM_TMO_BASE = 129,
  parameter int WAIT_BASE    = 512,
  parameter int REC_TMO_BASE = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic              over,
  input  logic              in_band,
  input  logic              pend_any,
  input  logic [GAIN_W-1:0] gain_l,
  input  logic [GAIN_W-1:0] gain_r,
  input  logic              cfg_limit_en,
  input  logic              cfg_recover_en,
  input  logic [2:0]        cfg_att_step,
  input  logic              cfg_lim_zc,
  input  logic [1:0]        cfg_lim_time,
  input  logic [1:0]        cfg_wait_time,
  input  logic [1:0]        cfg_rec_step,
  input  logic              cfg_rec_zc,
  input  logic [1:0]        cfg_rec_time,
  input  logic [GAIN_W-1:0] cfg_ref_gain,
  output logic              man_load,
  output logic              issue,
  output logic [GAIN_W-1:0] issue_gain,
  output logic              issue_zc,
  output logic [CNT_W-1:0]  issue_lim,
  output logic              done
);
  import slc_pkg::*;

  localparam logic [GAIN_W-1:0] MAX_CODE = GAIN_W'(GAIN_MAX);

  ctrl_state_t       st, st_n;
  logic [CNT_W-1:0]  wcnt, wcnt_n, wcnt_inc;
  logic              done_n;

  logic [GAIN_W-1:0] g_min;
  logic [GAIN_W-1:0] att;
  logic [GAIN_W-1:0] lim_gain;
  logic [GAIN_W:0]   rec_sum;
  logic [GAIN_W-1:0] rec_cap;
  logic [GAIN_W-1:0] rec_gain;
  logic [CNT_W-1:0]  lim_len;
  logic [CNT_W-1:0]  rec_len;
  logic [CNT_W-1:0]  wait_len;
  ctrl_state_t       settle_st;

  assign g_min    = (gain_l < gain_r) ? gain_l : gain_r;
  assign att      = GAIN_W'(cfg_att_step) + 1'b1;
  assign lim_gain = (g_min > att) ? (g_min - att) : '0;
  assign rec_sum  = {1'b0, g_min} + (GAIN_W+1)'(cfg_rec_step) + 1'b1;
  assign rec_cap  = (cfg_ref_gain < MAX_CODE) ? cfg_ref_gain : MAX_CODE;
  assign rec_gain = (rec_sum > {1'b0, rec_cap}) ? rec_cap : rec_sum[GAIN_W-1:0];

  assign lim_len  = cfg_lim_zc ? (CNT_W'(LIM_TMO_BASE) << cfg_lim_time)
                               : (CNT_W'(1) << cfg_lim_time);
  assign rec_len  = cfg_rec_zc ? ((CNT_W'(REC_TMO_BASE) << cfg_rec_time) + 1'b1)
                               : CNT_W'(1);
  assign wait_len = CNT_W'(WAIT_BASE) << cfg_wait_time;
  assign wcnt_inc = wcnt + 1'b1;

  assign settle_st = cfg_recover_en ? ST_WAIT : ST_HOLD;
  assign man_load  = (st == ST_MANUAL);

  always_comb begin
    st_n       = st;
    wcnt_n     = wcnt;
    done_n     = done;
    issue      = 1'b0;
    issue_gain = lim_gain;
    issue_zc   = cfg_lim_zc;
    issue_lim  = lim_len;
    unique case (st)
      ST_MANUAL: begin
        done_n = 1'b1;
        wcnt_n = '0;
        if (cfg_limit_en) st_n = settle_st;
      end
      ST_HOLD, ST_WAIT: begin
        if (!cfg_limit_en) begin
          st_n   = ST_MANUAL;
          done_n = 1'b1;
        end else if (smp_valid) begin
          if (over) begin
            issue  = 1'b1;
            st_n   = ST_LIMIT;
            done_n = 1'b0;
          end else if (st == ST_WAIT) begin
            if (!cfg_recover_en) begin
              st_n = ST_HOLD;
            end else if (in_band) begin
              wcnt_n = '0;
            end else if (wcnt_inc == wait_len) begin
              wcnt_n = '0;
              if (g_min < rec_cap) begin
                issue      = 1'b1;
                issue_gain = rec_gain;
                issue_zc   = cfg_rec_zc;
                issue_lim  = rec_len;
                st_n       = ST_RECOVER;
                done_n     = 1'b0;
              end
            end else begin
              wcnt_n = wcnt_inc;
            end
          end
        end
      end
      ST_LIMIT: begin
        if (!pend_any) begin
          if (!cfg_limit_en) begin
            st_n   = ST_MANUAL;
            done_n = 1'b1;
          end else if (smp_valid) begin
            if (over) begin
              issue = 1'b1;
            end else begin
              st_n   = settle_st;
              wcnt_n = '0;
              done_n = 1'b1;
            end
          end
        end
      end
      ST_RECOVER: begin
        if (cfg_limit_en && smp_valid && over) begin
          issue  = 1'b1;
          st_n   = ST_LIMIT;
          done_n = 1'b0;
        end else if (!pend_any) begin
          if (!cfg_limit_en) begin
            st_n   = ST_MANUAL;
            done_n = 1'b1;
          end else if (smp_valid) begin
            st_n   = settle_st;
            wcnt_n = '0;
            done_n = 1'b1;
          end
        end
      end
      default: begin
        st_n   = ST_MANUAL;
        done_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_MANUAL;
      wcnt <= '0;
      done <= 1'b1;
    end else begin
      st   <= st_n;
      wcnt <= wcnt_n;
      done <= done_n;
    end
  end

endmodule

// File: rtl/stereo_level_ctrl.sv
module stereo_level_ctrl #(
  parameter int SMP_W        = 16,
  parameter int GAIN_W       = 7,
  parameter int CNT_W        = 13,
  parameter int GAIN_MAX     = 104,
  parameter int RST_GAIN     = 48,
  parameter int LIM_TMO_BASE = 129,
  parameter int WAIT_BASE    = 512,
  parameter int REC_TMO_BASE = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_left,
  input  logic [SMP_W-1:0]  smp_right,
  input  logic              cfg_limit_en,
  input  logic              cfg_recover_en,
  input  logic [1:0]        cfg_thr_sel,
  input  logic [2:0]        cfg_att_step,
  input  logic              cfg_lim_zc,
  input  logic [1:0]        cfg_lim_time,
  input  logic [1:0]        cfg_wait_time,
  input  logic [1:0]        cfg_rec_step,
  input  logic              cfg_rec_zc,
  input  logic [1:0]        cfg_rec_time,
  input  logic [GAIN_W-1:0] cfg_ref_gain,
  input  logic [GAIN_W-1:0] man_gain_left,
  input  logic [GAIN_W-1:0] man_gain_right,
  output logic [GAIN_W-1:0] gain_left,
  output logic [GAIN_W-1:0] gain_right,
  output logic              done
);
  localparam int NCH = 2;

  logic              over;
  logic              in_band;
  logic [NCH-1:0]    zc;
  logic [NCH-1:0]    pend;
  logic              pend_any;
  logic              man_load;
  logic              issue;
  logic [GAIN_W-1:0] issue_gain;
  logic              issue_zc;
  logic [CNT_W-1:0]  issue_lim;
  logic [GAIN_W-1:0] ch_gain [NCH];
  logic [GAIN_W-1:0] ch_man  [NCH];

  assign ch_man[0]  = man_gain_left;
  assign ch_man[1]  = man_gain_right;
  assign gain_left  = ch_gain[0];
  assign gain_right = ch_gain[1];
  assign pend_any   = |pend;

  slc_level_detect #(.SMP_W(SMP_W)) i_detect (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_l     (smp_left),
    .smp_r     (smp_right),
    .thr_sel   (cfg_thr_sel),
    .over      (over),
    .in_band   (in_band),
    .zc        (zc)
  );

  slc_ctrl #(
    .GAIN_W       (GAIN_W),
    .CNT_W        (CNT_W),
    .GAIN_MAX     (GAIN_MAX),
    .LIM_TMO_BASE (LIM_TMO_BASE),
    .WAIT_BASE    (WAIT_BASE),
    .REC_TMO_BASE (REC_TMO_BASE)
  ) i_ctrl (
    .clk            (clk),
    .rst            (rst),
    .smp_valid      (smp_valid),
    .over           (over),
    .in_band        (in_band),
    .pend_any       (pend_any),
    .gain_l         (ch_gain[0]),
    .gain_r         (ch_gain[1]),
    .cfg_limit_en   (cfg_limit_en),
    .cfg_recover_en (cfg_recover_en),
    .cfg_att_step   (cfg_att_step),
    .cfg_lim_zc     (cfg_lim_zc),
    .cfg_lim_time   (cfg_lim_time),
    .cfg_wait_time  (cfg_wait_time),
    .cfg_rec_step   (cfg_rec_step),
    .cfg_rec_zc     (cfg_rec_zc),
    .cfg_rec_time   (cfg_rec_time),
    .cfg_ref_gain   (cfg_ref_gain),
    .man_load       (man_load),
    .issue          (issue),
    .issue_gain     (issue_gain),
    .issue_zc       (issue_zc),
    .issue_lim      (issue_lim),
    .done           (done)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_apply
      slc_gain_apply #(
        .GAIN_W   (GAIN_W),
        .CNT_W    (CNT_W),
        .GAIN_MAX (GAIN_MAX),
        .RST_GAIN (RST_GAIN)
      ) i_apply (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_zc     (zc[c]),
        .load       (man_load),
        .load_gain  (ch_man[c]),
        .issue      (issue),
        .issue_gain (issue_gain),
        .issue_zc   (issue_zc),
        .issue_lim  (issue_lim),
        .gain       (ch_gain[c]),
        .pend       (pend[c])
      );
    end
  endgenerate

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 104
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic              man_load,
  input logic              pend_any,
  input logic              cfg_limit_en,
  input logic [GAIN_W-1:0] cfg_ref_gain,
  input logic [GAIN_W-1:0] gain_left,
  input logic [GAIN_W-1:0] gain_right,
  input logic              done
);

  // R5
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !man_load) |=> ($stable(gain_left) && $stable(gain_right)));

  // R2
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_left <= GAIN_MAX) && (gain_right <= GAIN_MAX));

  // R9
  rec_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    !man_load |=> ((gain_left <= $past(gain_left)) || (gain_left <= cfg_ref_gain)));

  // R7
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(smp_valid));

  // R11
  done_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_limit_en && !pend_any) |=> done);

endmodule

bind stereo_level_ctrl slc_checker #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) i_slc_checker (
  .clk          (clk),
  .rst          (rst),
  .smp_valid    (smp_valid),
  .man_load     (man_load),
  .pend_any     (pend_any),
  .cfg_limit_en (cfg_limit_en),
  .cfg_ref_gain (cfg_ref_gain),
  .gain_left    (gain_left),
  .gain_right   (gain_right),
  .done         (done)
);

// File: tb/test_stereo_level_ctrl.sv
module test_stereo_level_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        cfg_limit_en = 1'b0;
  logic        cfg_recover_en = 1'b0;
  logic [1:0]  cfg_thr_sel = 2'd3;
  logic [2:0]  cfg_att_step = 3'd1;
  logic        cfg_lim_zc = 1'b0;
  logic [1:0]  cfg_lim_time = 2'd0;
  logic [1:0]  cfg_wait_time = 2'd0;
  logic [1:0]  cfg_rec_step = 2'd2;
  logic        cfg_rec_zc = 1'b0;
  logic [1:0]  cfg_rec_time = 2'd0;
  logic [6:0]  cfg_ref_gain = 7'h40;
  logic [6:0]  man_gain_left = 7'h40;
  logic [6:0]  man_gain_right = 7'h40;
  logic [6:0]  gain_left;
  logic [6:0]  gain_right;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stereo_level_ctrl i_stereo_level_ctrl (
    .clk            (clk),
    .rst            (rst),
    .smp_valid      (smp_valid),
    .smp_left       (smp_left),
    .smp_right      (smp_right),
    .cfg_limit_en   (cfg_limit_en),
    .cfg_recover_en (cfg_recover_en),
    .cfg_thr_sel    (cfg_thr_sel),
    .cfg_att_step   (cfg_att_step),
    .cfg_lim_zc     (cfg_lim_zc),
    .cfg_lim_time   (cfg_lim_time),
    .cfg_wait_time  (cfg_wait_time),
    .cfg_rec_step   (cfg_rec_step),
    .cfg_rec_zc     (cfg_rec_zc),
    .cfg_rec_time   (cfg_rec_time),
    .cfg_ref_gain   (cfg_ref_gain),
    .man_gain_left  (man_gain_left),
    .man_gain_right (man_gain_right),
    .gain_left      (gain_left),
    .gain_right     (gain_right),
    .done           (done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int gl, input int gr, input int dn);
    check(req, "gain_left", int'(gain_left), gl);
    check(req, "gain_right", int'(gain_right), gr);
    check(req, "done", int'(done), dn);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input int l, input int r);
    smp_left  = 16'(l);
    smp_right = 16'(r);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic send_n(input int n, input int l, input int r);
    for (int i = 0; i < n; i++) send(l, r);
  endtask

  task automatic setup(input bit lim, input bit rec, input int ml, input int mr);
    cfg_limit_en   = 1'b0;
    cfg_recover_en = rec;
    man_gain_left  = 7'(ml);
    man_gain_right = 7'(mr);
    smp_valid      = 1'b0;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick(); tick();
    cfg_limit_en = lim;
    tick();
  endtask

  task automatic t_reset_manual();
    man_gain_left  = 7'h40;
    man_gain_right = 7'h22;
    rst = 1'b1;
    tick(); tick();
    check_state("R1", 'h30, 'h30, 1);
    rst = 1'b0;
    tick();
    check_state("R2", 'h40, 'h22, 1);
    send(30000, -32768);
    check_state("R2", 'h40, 'h22, 1);
    man_gain_left = 7'h7F;
    tick();
    check("R2", "saturated manual gain", int'(gain_left), 'h68);
  endtask

  task automatic t_threshold();
    cfg_thr_sel = 2'd3; cfg_att_step = 3'd1; cfg_lim_zc = 1'b0; cfg_lim_time = 2'd0;
    setup(1, 0, 'h40, 'h40);
    send(26028, -26028);
    check("R3", "done below -2 dB", int'(done), 1);
    send(1000, 26029);
    check("R7", "done after loud strobe", int'(done), 0);
    send(100, 100);
    check_state("R4", 'h3E, 'h3E, 0);
    send(100, 100);
    check("R7", "done after quiet strobe", int'(done), 1);
    send(-32768, 0);
    check("R3", "full negative is loud", int'(done), 0);
    send(100, 100);
    check("R4", "second step", int'(gain_left), 'h3C);
    cfg_thr_sel = 2'd0;
    send(100, 100);
    send(13045, -13045);
    check("R3", "done below -8 dB", int'(done), 1);
    send(1000, -13046);
    check("R3", "loud at -8 dB", int'(done), 0);
    send(100, 100);
    send(20000, 100);
    check("R7", "repeat while loud", int'(gain_left), 'h3A);
    send(100, 100);
    check("R7", "repeated step lands", int'(gain_left), 'h38);
  endtask

  task automatic t_clip_and_min();
    cfg_thr_sel = 2'd3; cfg_att_step = 3'd7; cfg_lim_zc = 1'b0; cfg_lim_time = 2'd0;
    setup(1, 0, 'h03, 'h10);
    send(30000, 0);
    send(100, 100);
    check_state("R4", 0, 0, 0);
    cfg_att_step = 3'd0;
    setup(1, 0, 'h40, 'h20);
    send(100, 30000);
    send(100, 100);
    check_state("R4", 'h1F, 'h1F, 0);
  endtask

  task automatic t_period();
    cfg_thr_sel = 2'd3; cfg_att_step = 3'd0; cfg_lim_zc = 1'b0; cfg_lim_time = 2'd2;
    setup(1, 0, 'h40, 'h40);
    send(30000, 30000);
    send_n(3, 100, 100);
    check("R5", "gain before 4th strobe", int'(gain_left), 'h40);
    tick(); tick();
    check("R5", "no change without strobe", int'(gain_right), 'h40);
    send(100, 100);
    check_state("R5", 'h3F, 'h3F, 0);
  endtask

  task automatic t_zero_cross();
    cfg_thr_sel = 2'd3; cfg_att_step = 3'd1; cfg_lim_zc = 1'b1; cfg_lim_time = 2'd0;
    setup(1, 0, 'h40, 'h40);
    send(1000, 1000);
    send(30000, 1000);
    send(1000, 1000);
    check_state("R6", 'h40, 'h40, 0);
    send(-1000, 1000);
    check_state("R6", 'h3E, 'h40, 0);
    send(1000, 0);
    check_state("R6", 'h3E, 'h3E, 0);
    send(1000, 1000);
    check("R7", "done after both landed", int'(done), 1);
    send(30000, 1000);
    send_n(128, 1000, 1000);
    check("R6", "before timeout", int'(gain_left), 'h3E);
    send(1000, 1000);
    check_state("R6", 'h3C, 'h3C, 0);
  endtask

  task automatic t_recovery();
    cfg_thr_sel = 2'd3; cfg_wait_time = 2'd0; cfg_rec_step = 2'd2; cfg_rec_zc = 1'b0;
    cfg_ref_gain = 7'h40; cfg_att_step = 3'd1; cfg_lim_zc = 1'b0; cfg_lim_time = 2'd0;
    setup(1, 1, 'h3C, 'h3C);
    send_n(300, 100, 100);
    send(20675, 100);
    send_n(511, 100, 100);
    check_state("R8", 'h3C, 'h3C, 1);
    send(100, 100);
    check("R8", "recovery issued at 512", int'(done), 0);
    send(100, 100);
    check_state("R9", 'h3F, 'h3F, 0);
    send(100, 100);
    send_n(511, 20674, 100);
    check_state("R8", 'h3F, 'h3F, 1);
    send(100, 100);
    send(100, 100);
    check_state("R9", 'h40, 'h40, 0);
    send(100, 100);
    send_n(600, 100, 100);
    check_state("R8", 'h40, 'h40, 1);
  endtask

  task automatic t_abandon();
    cfg_thr_sel = 2'd3; cfg_wait_time = 2'd0; cfg_rec_step = 2'd2; cfg_rec_zc = 1'b1;
    cfg_rec_time = 2'd0; cfg_ref_gain = 7'h40; cfg_att_step = 3'd1;
    cfg_lim_zc = 1'b0; cfg_lim_time = 2'd0;
    setup(1, 1, 'h3C, 'h3C);
    send_n(512, 1000, 1000);
    send_n(512, 1000, 1000);
    check_state("R9", 'h3C, 'h3C, 0);
    send(1000, 1000);
    check_state("R9", 'h3F, 'h3F, 0);
    send(1000, 1000);
    send_n(512, 1000, 1000);
    send_n(10, 1000, 1000);
    check("R9", "pending recovery", int'(gain_left), 'h3F);
    send(30000, 1000);
    send(1000, 1000);
    check_state("R10", 'h3D, 'h3D, 0);
    send(1000, 1000);
    check("R10", "done after limit", int'(done), 1);
  endtask

  task automatic t_disable();
    cfg_thr_sel = 2'd3; cfg_att_step = 3'd1; cfg_lim_zc = 1'b1; cfg_lim_time = 2'd0;
    setup(1, 0, 'h40, 'h40);
    send(1000, 1000);
    send(30000, 1000);
    cfg_limit_en   = 1'b0;
    man_gain_left  = 7'h50;
    man_gain_right = 7'h50;
    send_n(3, 1000, 1000);
    send(30000, 1000);
    check_state("R11", 'h40, 'h40, 0);
    send(-1000, -1000);
    check_state("R11", 'h3E, 'h3E, 0);
    tick();
    check("R11", "done after pending step", int'(done), 1);
    tick();
    check_state("R11", 'h50, 'h50, 1);
    send(-1000, -1000);
    send(30000, 30000);
    check_state("R11", 'h50, 'h50, 1);
  endtask

  task automatic t_recover_needs_limit();
    cfg_thr_sel = 2'd3; cfg_wait_time = 2'd0; cfg_rec_zc = 1'b0; cfg_ref_gain = 7'h40;
    setup(0, 1, 'h30, 'h30);
    send_n(600, 100, 100);
    check_state("R12", 'h30, 'h30, 1);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    tick();
    t_reset_manual();
    t_threshold();
    t_clip_and_min();
    t_period();
    t_zero_cross();
    t_recovery();
    t_abandon();
    t_disable();
    t_recover_needs_limit();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule